// File: doc/BRIEF.md
# Adder-Tree Thermometer-to-Binary Encoder

This block sits behind a bank of comparators in a flash converter. It receives the 2^K-1 comparator decisions, which for a clean sample form a thermometer word: bit i is 1 when the analog input is above the i-th reference level, and the levels are one LSB apart. It returns a K-bit binary code. The code is the number of ones in the word. No priority logic or edge detection is involved.

The count comes from a tree of full-adder cells. Each first-level cell reduces three comparator bits to a 2-bit count. Each full-adder cell is two half adders whose carries are ORed. Spare inputs in the last group are tied low. Higher levels add neighbouring counts in pairs until a single sum is left. Because the result is a population count, a word with bubbles still produces its exact number of ones, and no error flag is raised. The resolution K may be 3, 4 or 5. A parameter can place a register on the output.

Top module: `therm_popcount_enc`

## Requirements
- R1: The input is 2^K-1 bits wide and the output is K bits wide. For any thermometer word with n ones in bits 0 to n-1, the code equals n.
- R2: An all-zero input gives code 0.
- R3: An all-ones input gives code 2^K-1.
- R4: A word that is not a thermometer pattern (bubbles) gives its exact count of ones. No other indication is produced.
- R5: With REG_OUT=1, the code for an input sampled at a rising clock edge appears after that edge. It holds until the next rising edge, even if the input changes in between.
- R6: With REG_OUT=1, rst_i high at a rising edge sets the output to 0 (synchronous, active high).
- R7: With REG_OUT=0, the output follows the input combinationally, with no clock involved.
- R8: The same source gives correct codes for K = 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_i | input | 1 | Synchronous active-high reset of the output register |
| therm_i | input | 2^K-1 | Comparator decisions, bit 0 is the lowest reference level |
| code_o | output | K | Count of ones in therm_i |

## Verification
On every cycle, the assertions compare the output with the count of ones in the previously sampled input, or in the current input when unregistered. They also check the all-zero and all-ones extremes and the reset value. Only the bench scenarios can show the rest. These cover every thermometer pattern at each resolution, words with bubbles, and the output holding while the input changes between edges. They also show a reset asserted in the middle of operation clearing a non-zero result.

// File: rtl/therm_popcount_enc.sv
module therm_popcount_enc #(
  parameter int K       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [(1<<K)-2:0]  therm_i,
  output logic [K-1:0]       code_o
);
  localparam int N    = (1 << K) - 1;
  localparam int G    = (N + 2) / 3;
  localparam int PADN = 3 * G;
  localparam int P    = 1 << $clog2(G);

  logic [PADN-1:0]        padded;
  logic [2*P-1:1][K-1:0]  node;
  logic [K-1:0]           total;

  assign padded = PADN'(therm_i);

  for (genvar g = 0; g < P; g++) begin : g_leaf
    if (g < G) begin : g_fa
      logic a, b, c, s1, c1, s, c2, co;
      assign a  = padded[3*g];
      assign b  = padded[3*g+1];
      assign c  = padded[3*g+2];
      assign s1 = a ^ b;
      assign c1 = a & b;
      assign s  = s1 ^ c;
      assign c2 = s1 & c;
      assign co = c1 | c2;
      assign node[P+g] = K'({co, s});
    end else begin : g_nil
      assign node[P+g] = '0;
    end
  end

  for (genvar i = 1; i < P; i++) begin : g_sum
    assign node[i] = node[2*i] + node[2*i+1];
  end

  assign total = node[1];

  if (REG_OUT) begin : g_reg
    logic [K-1:0] code_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) code_q <= '0;
      else       code_q <= total;
    end
    assign code_o = code_q;
  end else begin : g_comb
    assign code_o = total;
  end
endmodule

// File: rtl/therm_popcount_enc_chk.sv
module therm_popcount_enc_chk #(
  parameter int K       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [(1<<K)-2:0] therm_i,
  input logic [K-1:0]      code_o
);
  localparam int N = (1 << K) - 1;
  logic armed = 1'b0;
  always_ff @(posedge clk_i) if (rst_i) armed <= 1'b1;

  if (REG_OUT) begin : g_reg
    a_r1_count: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && !$past(rst_i) |-> int'(code_o) == $countones($past(therm_i)));
    a_r2_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && !$past(rst_i) && $past(therm_i) == '0 |-> code_o == '0);
    a_r3_full: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && !$past(rst_i) && (&$past(therm_i)) |-> int'(code_o) == N);
    a_r6_reset: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && $past(rst_i) |-> code_o == '0);
  end else begin : g_comb
    a_r7_comb: assert property (@(posedge clk_i) disable iff (rst_i)
      armed |-> int'(code_o) == $countones(therm_i));
    a_r2_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && therm_i == '0 |-> code_o == '0);
    a_r3_full: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && (&therm_i) |-> int'(code_o) == N);
    a_r4_bubble: assert property (@(posedge clk_i) disable iff (rst_i)
      armed && therm_i[0] == 1'b0 && therm_i != '0 |-> int'(code_o) == $countones(therm_i));
  end
endmodule

bind therm_popcount_enc therm_popcount_enc_chk #(.K(K), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/therm_popcount_enc_tb_top.sv
module therm_popcount_enc_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [14:0] t4 = '0, tc = '0;
  logic [6:0]  t3 = '0;
  logic [30:0] t5 = '0;
  logic [3:0]  c4, cc;
  logic [2:0]  c3;
  logic [4:0]  c5;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  therm_popcount_enc #(.K(4), .REG_OUT(1'b1)) dut_i  (.clk_i(clk), .rst_i(rst), .therm_i(t4), .code_o(c4));
  therm_popcount_enc #(.K(3), .REG_OUT(1'b1)) dut3_i (.clk_i(clk), .rst_i(rst), .therm_i(t3), .code_o(c3));
  therm_popcount_enc #(.K(5), .REG_OUT(1'b1)) dut5_i (.clk_i(clk), .rst_i(rst), .therm_i(t5), .code_o(c5));
  therm_popcount_enc #(.K(4), .REG_OUT(1'b0)) dutc_i (.clk_i(clk), .rst_i(rst), .therm_i(tc), .code_o(cc));

  function automatic int pc(logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic t_reset();
    t4 = 15'h7fff; t3 = 7'h7f; t5 = '1;
    repeat (2) @(posedge clk);
    #1;
    chk("R6 reset k4", int'(c4), 0);
    chk("R6 reset k3", int'(c3), 0);
    chk("R6 reset k5", int'(c5), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_thermo();
    for (int n = 0; n <= 31; n++) begin
      @(negedge clk);
      t5 = 31'((32'd1 << n) - 1);
      if (n <= 15) begin t4 = 15'((32'd1 << n) - 1); tc = t4; end
      if (n <= 7)  t3 = 7'((32'd1 << n) - 1);
      #1;
      if (n <= 15) chk("R7 comb thermo", int'(cc), n);
      @(posedge clk); #1;
      chk("R1 R8 thermo k5", int'(c5), n);
      if (n <= 15) chk("R1 R8 thermo k4", int'(c4), n);
      if (n <= 7)  chk("R1 R8 thermo k3", int'(c3), n);
    end
  endtask

  task automatic t_bounds();
    @(negedge clk); t3 = '0; t4 = '0; t5 = '0; tc = '0;
    #1 chk("R2 comb zero", int'(cc), 0);
    @(posedge clk); #1;
    chk("R2 zero k3", int'(c3), 0);
    chk("R2 zero k4", int'(c4), 0);
    chk("R2 zero k5", int'(c5), 0);
    @(negedge clk); t3 = '1; t4 = '1; t5 = '1; tc = '1;
    #1 chk("R3 comb full", int'(cc), 15);
    @(posedge clk); #1;
    chk("R3 full k3", int'(c3), 7);
    chk("R3 full k4", int'(c4), 15);
    chk("R3 full k5", int'(c5), 31);
  endtask

  task automatic t_bubbles();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      t5 = 31'($urandom); t4 = 15'($urandom); t3 = 7'($urandom); tc = 15'($urandom);
      if (i == 0) begin t4 = 15'b000_0000_1011_0111; t3 = 7'b010_1101; end
      #1 chk("R4 comb bubble", int'(cc), pc(32'(tc)));
      @(posedge clk); #1;
      chk("R4 bubble k5", int'(c5), pc(32'(t5)));
      chk("R4 bubble k4", int'(c4), pc(32'(t4)));
      chk("R4 bubble k3", int'(c3), pc(32'(t3)));
    end
  endtask

  task automatic t_latency();
    @(negedge clk); t4 = 15'h00ff;
    @(posedge clk); #1 chk("R5 sampled", int'(c4), 8);
    @(negedge clk); t4 = 15'h0003;
    #1 chk("R5 hold between edges", int'(c4), 8);
    @(posedge clk); #1 chk("R5 after edge", int'(c4), 2);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); t4 = '1;
    @(posedge clk); #1 chk("R6 before reset", int'(c4), 15);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 chk("R6 mid reset", int'(c4), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 chk("R6 after release", int'(c4), 15);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_thermo();
    t_bounds();
    t_bubbles();
    t_latency();
    t_reset_mid();
    finish_run();
  end
endmodule